// File: doc/BRIEF.md
# Flash Read Wait-State and Busy-Collision Arbiter

This block sits between a single-beat bus read port and the read port of a flash array. Each read is held for a programmable number of extra cycles so the array's access time is met. A read can arrive while the array is busy with a program or erase. A 3-bit policy then decides what happens: the bus always stalls, and the policy chooses whether an abort is sent to the array and whether a sticky notification flag is raised.

Configuration comes in through one write strobe and an 18-bit word. That word carries the read wait count, a pipelining field that must match the read wait count, a write wait field that is accepted but has no effect, and the collision policy. Only one read is in flight at a time. Read data passes straight from the array to the bus in the cycle that ready is high.

Top module: `flash_rd_arb`

## Requirements
- R1: After reset, rd_ready, arr_abort, irq_stall and irq_abort are 0. The read wait count is RST_RD_WS (default 3) and the policy is 3'b111.
- R2: A read presented with rd_req in cycle c, while the block is idle and arr_busy is 0, gets rd_ready high in cycle c+1+W only, where W is the read wait count. rd_data in that cycle equals arr_rdata for the latched address, and rd_ready is low in cycle c+2+W.
- R3: The read wait count is cfg_wdata[4:0], an unsigned value from 0 to 31 that adds that many cycles to every read.
- R4: If arr_busy is 1 in the acceptance cycle c, rd_ready stays low while arr_busy stays 1. If arr_busy is first seen low in cycle b, rd_ready is high in cycle b+1+W.
- R5: The policy is cfg_wdata[17:15]. Under policy 3'b111 a colliding read only stalls: arr_abort stays 0 and neither flag is set.
- R6: Under policy 3'b110 a colliding read stalls and sets irq_stall from the next cycle. arr_abort stays 0.
- R7: Under policy 3'b101 a colliding read stalls and drives arr_abort high in the acceptance cycle only. No flag is set.
- R8: Under policy 3'b100 a colliding read does what R7 describes and also sets irq_abort from the next cycle.
- R9: The flags hold their value until cleared by a 1 on irq_clr, where bit 0 clears irq_stall and bit 1 clears irq_abort. If a set and a clear fall in the same cycle, the set wins.
- R10: rd_req is ignored from the acceptance cycle until the cycle after rd_ready. No extra read is returned, and the data belongs to the accepted address.
- R11: The write wait field cfg_wdata[14:10] has no effect on read timing. The pipelining field cfg_wdata[9:5] must equal cfg_wdata[4:0]. Policies with bit 17 equal to 0 are unsupported.
- R12: A configuration written with cfg_we in cycle c applies to every read accepted after cycle c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 18 | Configuration word (fields in R3, R5, R11) |
| irq_clr | input | 2 | Write-one-to-clear for the flags |
| rd_req | input | 1 | Bus read request |
| rd_addr | input | AW (16) | Bus read address |
| rd_data | output | DW (32) | Read data, valid with rd_ready |
| rd_ready | output | 1 | Read completion, one cycle |
| arr_rd | output | 1 | Array read in progress |
| arr_addr | output | AW (16) | Latched address to the array |
| arr_rdata | input | DW (32) | Array read data |
| arr_busy | input | 1 | Array busy with program or erase |
| arr_abort | output | 1 | One-cycle abort request to the array |
| irq_stall | output | 1 | Sticky stall notification flag |
| irq_abort | output | 1 | Sticky abort notification flag |

## Verification
Assertions check on every cycle that ready is a single-cycle pulse, that no ready appears while a stalled read still sees the array busy, and that an abort only goes out with a busy array and a policy that allows it. They also check that the counter reloads the configured count, that flags set after a matching collision and stay set until cleared, and that configuration words keep the pipelining field equal to the read field. Only the bench scenarios can show exact latencies across the full 0 to 31 wait range and after stalls of different lengths. The same holds for the data returned while new requests are held high, for the set-beats-clear ordering, and for the write wait field leaving timing unchanged.

// File: rtl/flrd_pkg.sv
`timescale 1ns/1ps
package flrd_pkg;
  localparam int WS_W   = 5;
  localparam int POL_W  = 3;
  localparam int CFG_W  = 18;
  localparam int RD_LSB = 0;
  localparam int PP_LSB = 5;
  localparam int WR_LSB = 10;
  localparam int PO_LSB = 15;
  localparam logic [POL_W-1:0] POL_RESET = 3'b111;

  typedef enum logic [1:0] {ST_IDLE, ST_STALL, ST_ACC} rd_state_e;

  // policy decode: bit1 low -> abort; bit0 low -> notify
  function automatic logic pol_abort(input logic [POL_W-1:0] p);
    return !p[1];
  endfunction

  function automatic logic pol_stall_irq(input logic [POL_W-1:0] p);
    return p[1] && !p[0];
  endfunction

  function automatic logic pol_abort_irq(input logic [POL_W-1:0] p);
    return !p[1] && !p[0];
  endfunction

  // cycles from acceptance (or end of stall) to ready
  function automatic int read_latency(input logic [WS_W-1:0] ws);
    return int'(ws) + 1;
  endfunction
endpackage

// File: rtl/flrd_cfg_reg.sv
`timescale 1ns/1ps
module flrd_cfg_reg
  import flrd_pkg::*;
#(
  parameter logic [WS_W-1:0] RST_RD_WS = 5'd3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [WS_W-1:0]   rd_ws_q,
  output logic [POL_W-1:0]  policy_q
);
  logic [WS_W-1:0]  rd_field;
  logic [WS_W-1:0]  pipe_field;
  logic [WS_W-1:0]  wr_field;
  logic [POL_W-1:0] pol_field;
  logic             wr_field_write;

  assign rd_field   = cfg_wdata[RD_LSB +: WS_W];
  assign pipe_field = cfg_wdata[PP_LSB +: WS_W];
  assign wr_field   = cfg_wdata[WR_LSB +: WS_W];
  assign pol_field  = cfg_wdata[PO_LSB +: POL_W];
  // event: a write carrying a non-zero write wait field
  assign wr_field_write = cfg_we && (wr_field != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ws_q  <= RST_RD_WS;
      policy_q <= POL_RESET;
    end else if (cfg_we) begin
      rd_ws_q  <= rd_field;
      policy_q <= pol_field;
    end
  end

  p_pipe_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (pipe_field == rd_field));
  p_policy_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> pol_field[2]);
  p_wr_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_field_write |=> (rd_ws_q == $past(rd_field)));
endmodule

// File: rtl/flrd_wait_ctr.sv
`timescale 1ns/1ps
module flrd_wait_ctr
  import flrd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [WS_W-1:0] load_val,
  input  logic            en,
  output logic            done
);
  logic [WS_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (en && !done)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  p_cnt_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
  p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && !done) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/flrd_busy_policy.sv
`timescale 1ns/1ps
module flrd_busy_policy
  import flrd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             collide,
  input  logic [POL_W-1:0] policy,
  input  logic [1:0]       irq_clr,
  output logic             arr_abort,
  output logic             irq_stall,
  output logic             irq_abort
);
  logic set_stall;
  logic set_abort;

  assign arr_abort = collide && pol_abort(policy);
  assign set_stall = collide && pol_stall_irq(policy);
  assign set_abort = collide && pol_abort_irq(policy);

  // set has priority over a same-cycle clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_stall <= 1'b0;
      irq_abort <= 1'b0;
    end else begin
      irq_stall <= set_stall || (irq_stall && !irq_clr[0]);
      irq_abort <= set_abort || (irq_abort && !irq_clr[1]);
    end
  end

  p_abort_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_abort |=> !arr_abort);
  p_stall_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    set_stall |=> irq_stall);
  p_abort_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_abort |=> irq_abort);
  p_stall_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_stall && !irq_clr[0]) |=> irq_stall);
  p_abort_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_abort && !irq_clr[1]) |=> irq_abort);
  p_stall_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr[0] && !set_stall) |=> !irq_stall);
endmodule

// File: rtl/flash_rd_arb.sv
`timescale 1ns/1ps
module flash_rd_arb
  import flrd_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter logic [WS_W-1:0] RST_RD_WS = 5'd3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic [1:0]       irq_clr,
  input  logic             rd_req,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data,
  output logic             rd_ready,
  output logic             arr_rd,
  output logic [AW-1:0]    arr_addr,
  input  logic [DW-1:0]    arr_rdata,
  input  logic             arr_busy,
  output logic             arr_abort,
  output logic             irq_stall,
  output logic             irq_abort
);
  rd_state_e        st_q, st_d;
  logic [AW-1:0]    addr_q;
  logic [WS_W-1:0]  rd_ws_q;
  logic [POL_W-1:0] policy_q;
  logic             accept;
  logic             collide;
  logic             ctr_load;
  logic             ctr_done;

  flrd_cfg_reg #(.RST_RD_WS(RST_RD_WS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .rd_ws_q(rd_ws_q), .policy_q(policy_q)
  );

  // named events for checking
  assign accept   = (st_q == ST_IDLE) && rd_req;
  assign collide  = accept && arr_busy;
  assign ctr_load = (accept && !arr_busy) || ((st_q == ST_STALL) && !arr_busy);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (rd_req) st_d = arr_busy ? ST_STALL : ST_ACC;
      ST_STALL: if (!arr_busy) st_d = ST_ACC;
      ST_ACC:   if (ctr_done) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) addr_q <= rd_addr;
    end
  end

  flrd_wait_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(rd_ws_q),
    .en(st_q == ST_ACC), .done(ctr_done)
  );

  flrd_busy_policy u_pol (
    .clk(clk), .rst_n(rst_n), .collide(collide), .policy(policy_q),
    .irq_clr(irq_clr), .arr_abort(arr_abort), .irq_stall(irq_stall),
    .irq_abort(irq_abort)
  );

  assign arr_rd   = (st_q == ST_ACC);
  assign arr_addr = addr_q;
  assign rd_ready = arr_rd && ctr_done;
  assign rd_data  = arr_rdata;

  p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready |=> !rd_ready);
  p_stall_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_STALL) && arr_busy) |=> !rd_ready);
  p_abort_needs_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_abort |-> (arr_busy && rd_req && !policy_q[1]));
  p_one_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_rd && !rd_ready) |=> $stable(arr_addr));
endmodule

// File: tb/tb_flash_rd_arb.sv
`timescale 1ns/1ps
module tb_flash_rd_arb;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int RST_WS = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [17:0] cfg_wdata = '0;
  logic [1:0] irq_clr = '0;
  logic rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic rd_ready, arr_rd, arr_abort, irq_stall, irq_abort;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_rdata;
  logic arr_busy = 1'b0;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  // array model: data is a fixed function of the address
  assign arr_rdata = {arr_addr ^ 16'h5A5A, arr_addr};

  flash_rd_arb #(.AW(AW), .DW(DW), .RST_RD_WS(5'(RST_WS))) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .irq_clr(irq_clr), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_ready(rd_ready), .arr_rd(arr_rd), .arr_addr(arr_addr),
    .arr_rdata(arr_rdata), .arr_busy(arr_busy), .arr_abort(arr_abort),
    .irq_stall(irq_stall), .irq_abort(irq_abort)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [17:0] mk_cfg(input int ws, input logic [2:0] pol,
                                         input int wr);
    return {pol, 5'(wr), 5'(ws), 5'(ws)};
  endfunction

  task automatic write_cfg(input logic [17:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // one read; busy_n cycles of array busy from the acceptance cycle
  task automatic run_read(input logic [AW-1:0] a, input int busy_n, input int ws,
                          input logic exp_abort, input logic [1:0] clr0,
                          input string tag);
    int exp_k;
    bit early;
    bit extra_abort;
    exp_k = busy_n + 1 + ws;
    early = 0;
    extra_abort = 0;
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a; arr_busy = (busy_n > 0); irq_clr = clr0;
    #1;
    chk(arr_abort == exp_abort, tag, "abort in acceptance cycle", arr_abort, exp_abort);
    for (int k = 1; k <= exp_k + 1; k++) begin
      @(negedge clk);
      irq_clr = '0;
      arr_busy = (k < busy_n);
      rd_req = (k < exp_k);          // R10: requests held high meanwhile
      rd_addr = a ^ AW'(k * 7 + 1);
      #1;
      if (arr_abort) extra_abort = 1;
      if (k < exp_k && rd_ready) early = 1;
      if (k == exp_k) begin
        chk(rd_ready == 1'b1, tag, "ready at expected cycle", rd_ready, 1);
        chk(rd_data == {a ^ 16'h5A5A, a}, tag, "read data", rd_data, {a ^ 16'h5A5A, a});
      end
      if (k == exp_k + 1)
        chk(rd_ready == 1'b0, tag, "ready single pulse (R10 no extra read)", rd_ready, 0);
    end
    chk(!early, tag, "no early ready", early, 0);
    chk(!extra_abort, "R7", "abort only in acceptance cycle", extra_abort, 0);
    rd_req = 1'b0;
  endtask

  task automatic clear_flags;
    @(negedge clk); irq_clr = 2'b11;
    @(negedge clk); irq_clr = 2'b00;
    #1;
    chk(!irq_stall && !irq_abort, "R9", "flags cleared", {irq_stall, irq_abort}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [2:0] pols [3];
    int wss [4];
    pols = '{3'b110, 3'b101, 3'b100};
    wss = '{0, 2, 7, 31};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!rd_ready && !arr_abort, "R1", "ready/abort at reset", {rd_ready, arr_abort}, 0);
    chk(!irq_stall && !irq_abort, "R1", "flags at reset", {irq_stall, irq_abort}, 0);
    run_read(16'h1234, 0, RST_WS, 1'b0, 2'b00, "R1");
    // R1/R5 reset policy only stalls
    run_read(16'h4321, 3, RST_WS, 1'b0, 2'b00, "R5");
    #1;
    chk(!irq_stall && !irq_abort, "R5", "no flags under stall-only", {irq_stall, irq_abort}, 0);

    // R2/R3/R12/R11 sweep of every wait count, write field varied
    for (int ws = 0; ws < 32; ws++) begin
      write_cfg(mk_cfg(ws, 3'b111, 31 - ws));
      run_read(16'(ws * 977 + 5), 0, ws, 1'b0, 2'b00, "R3");
    end
    // R11: write field extremes give the same timing
    write_cfg(mk_cfg(4, 3'b111, 0));
    run_read(16'hBEEF, 0, 4, 1'b0, 2'b00, "R11");
    write_cfg(mk_cfg(4, 3'b111, 31));
    run_read(16'hCAFE, 0, 4, 1'b0, 2'b00, "R11");
    // R4 stall lengths under plain policy
    for (int b = 1; b <= 6; b++)
      run_read(16'(b * 4099), b, 4, 1'b0, 2'b00, "R4");

    // R6/R7/R8 policies with collisions
    foreach (pols[i]) begin
      foreach (wss[j]) begin
        for (int b = 1; b <= 4; b += 3) begin
          write_cfg(mk_cfg(wss[j], pols[i], 9));
          run_read(16'(i * 311 + j * 53 + b), b, wss[j], !pols[i][1], 2'b00,
                   pols[i] == 3'b110 ? "R6" : (pols[i] == 3'b101 ? "R7" : "R8"));
          #1;
          chk(irq_stall == (pols[i] == 3'b110), "R6", "stall flag", irq_stall, pols[i] == 3'b110);
          chk(irq_abort == (pols[i] == 3'b100), "R8", "abort flag", irq_abort, pols[i] == 3'b100);
          clear_flags();
        end
      end
      // no collision: no abort, no flags
      run_read(16'h0F0F, 0, 31, 1'b0, 2'b00, "R2");
      #1;
      chk(!irq_stall && !irq_abort, "R2", "no flags without collision", {irq_stall, irq_abort}, 0);
    end

    // R9 sticky and set-wins
    write_cfg(mk_cfg(1, 3'b110, 0));
    run_read(16'h7777, 2, 1, 1'b0, 2'b00, "R9");
    repeat (10) @(negedge clk);
    #1;
    chk(irq_stall == 1'b1, "R9", "stall flag sticky", irq_stall, 1);
    clear_flags();
    run_read(16'h8888, 2, 1, 1'b0, 2'b01, "R9");
    #1;
    chk(irq_stall == 1'b1, "R9", "set wins over clear", irq_stall, 1);
    write_cfg(mk_cfg(0, 3'b100, 0));
    run_read(16'h9999, 1, 0, 1'b1, 2'b10, "R8");
    #1;
    chk(irq_abort == 1'b1, "R9", "abort set wins over clear", irq_abort, 1);
    chk(irq_stall == 1'b1, "R9", "other flag untouched by clear", irq_stall, 1);
    clear_flags();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule